// File: doc/BRIEF.md
# USB Full-Speed Receive Bit Recovery

This block takes the two wires of a USB full-speed receive pair, sampled by a clock running at four times the 12 Mbit/s bit rate, and recovers the bit timing from them. Both wires pass through a synchronizer. The pair is then decoded into one of four line states. A 2-bit phase counter places a sampling point near the middle of each bit cell. Each time the decoded line changes, the counter is pulled back toward the centre of the new cell by at most one clock. With no change on the line it free-runs with a period of four clocks.

Each recovered bit leaves the block as a single-cycle `bit_valid` pulse in the fast clock domain. The line state sampled at that point appears beside it. Downstream logic (NRZI decode, unstuffing, end-of-packet detection) accepts a bit only when the pulse is high. A free-running divided clock never samples the recovered bits. Because of this, a sender running slightly fast or slow causes neither a dropped bit nor a bit taken twice: the pulse spacing simply stretches or shrinks by one clock.

Top module: `usb_fs_rx_recover`

## Requirements
- R1: Each wire passes through two flip-flop stages before decode. A change driven on the pins of an armed-but-idle block produces its first `bit_valid` pulse exactly five clocks later: two synchronizer stages, one detection cycle, and two clocks to reach the cell centre.
- R2: `line_st` carries `{dp, dn}` as sampled at the strobe point. J = 2'b10, K = 2'b01, SE0 = 2'b00, SE1 = 2'b11. SE0 and SE1 are reported as bits in the same way as J and K.
- R3: A synchronous active-high reset drives `bit_valid` to 0 and `line_st` to J (2'b10). After reset, no pulse appears until the decoded line first differs from J.
- R4: While the decoded line stays unchanged, successive pulses are exactly four clocks apart.
- R5: For any input, two successive pulses are at least three and at most five clocks apart.
- R6: A change on the decoded line moves the sampling point by at most one clock relative to the free-running count. This sets the cycle of the next pulse: a change seen on time or one clock early gives a pulse two clocks after detection; one clock late gives a one-clock delay, allowed at most once per bit; two clocks off advances the point by one clock.
- R7: A bit stream driven at the nominal rate, at +0.25 % and at -0.25 % of it yields every transmitted bit, from the first change onward, reported exactly once and in order.
- R8: `bit_valid` is driven from a register and is never high on two consecutive clocks.
- R9: `line_st` changes only in a cycle where `bit_valid` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, four times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| dp_in | input | 1 | Positive wire of the receive pair, asynchronous |
| dn_in | input | 1 | Negative wire of the receive pair, asynchronous |
| bit_valid | output | 1 | One-cycle pulse marking a recovered bit |
| line_st | output | 2 | Line state at the last pulse, `{dp, dn}` |

## Verification
The bench drives streams whose edges fall at fractional positions: the sender runs 0.25 % slow or fast and starts at each of the four clock phases. This forces the late-by-one and early-by-one corrections. A design that corrected by the full error, or not at all, would show up as a missing or doubled bit in the recovered sequence. It would also show up as a pulse gap outside three to five clocks. Long runs of equal bits and the idle tail check the free-running period of four. A counter that wrapped at the wrong value, or a correction applied without an edge, would break the exact gap. The reset phase checks that no pulse comes out while the line idles at J. The first K must produce its pulse exactly five clocks after it is driven; an extra or missing synchronizer stage would shift it.

// File: rtl/usb_rx_pkg.sv
`timescale 1ns/1ps
package usb_rx_pkg;

  typedef logic [1:0] line_t;

  // {dp, dn}
  localparam line_t LINE_SE0 = 2'b00;
  localparam line_t LINE_K   = 2'b01;
  localparam line_t LINE_J   = 2'b10;
  localparam line_t LINE_SE1 = 2'b11;

  localparam int PH_W = 2;                  // log2 of oversampling ratio
  localparam int OSR  = 1 << PH_W;          // clocks per nominal bit
  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_ALIGN  = phase_t'(1);       // phase just after an edge
  localparam phase_t PH_LATE   = phase_t'(1);       // edge one clock late
  localparam phase_t PH_CENTER = phase_t'(OSR / 2); // sampling point
  localparam phase_t PH_FAR    = phase_t'(OSR / 2); // edge half a cell off

  // Next phase given current phase, edge flag and whether a delay was
  // already spent on the current bit. Never moves more than one clock
  // away from the free-running successor.
  function automatic phase_t next_phase(input phase_t p, input logic edge_now,
                                        input logic delay_used);
    phase_t succ;
    succ = p + phase_t'(1);
    if (!edge_now)            return succ;
    if (p == PH_LATE)         return delay_used ? succ : p;
    if (p == PH_FAR)          return p + phase_t'(2);
    return PH_ALIGN;
  endfunction

endpackage

// File: rtl/usb_rx_sync.sv
`timescale 1ns/1ps
module usb_rx_sync #(
  parameter int           STAGES  = 2,
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/usb_rx_phase.sv
`timescale 1ns/1ps
module usb_rx_phase
  import usb_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  line_t line_now,
  output logic  strobe
);

  localparam int GAP_W   = 4;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  line_t  line_prev;
  phase_t ph;
  logic   armed;
  logic   delay_used;
  logic   edge_seen;

  assign edge_seen = (line_now != line_prev);
  assign strobe    = armed && (ph == PH_CENTER);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_prev  <= LINE_J;
      ph         <= '0;
      armed      <= 1'b0;
      delay_used <= 1'b0;
    end else begin
      line_prev <= line_now;
      if (!armed) begin
        if (edge_seen) begin
          ph    <= PH_ALIGN;
          armed <= 1'b1;
        end else begin
          ph <= ph + phase_t'(1);
        end
      end else begin
        ph <= next_phase(ph, edge_seen, delay_used);
        if (edge_seen && ph == PH_LATE && !delay_used) delay_used <= 1'b1;
        else if (strobe)                               delay_used <= 1'b0;
      end
    end
  end

  // Checker state: clocks since last strobe, edges inside the interval.
  logic [GAP_W-1:0] gap;
  logic             seen_one;
  logic             edge_since;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap        <= '0;
      seen_one   <= 1'b0;
      edge_since <= 1'b0;
    end else begin
      if (strobe) begin
        gap        <= GAP_W'(1);
        seen_one   <= 1'b1;
        edge_since <= edge_seen;
      end else begin
        gap <= (gap == GAP_MAX) ? gap : gap + GAP_W'(1);
        if (edge_seen) edge_since <= 1'b1;
      end
    end
  end

  assert_gap_window_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe && seen_one) |-> (gap >= GAP_W'(OSR - 1) && gap <= GAP_W'(OSR + 1)))
    else $error("strobe spacing outside window");

  assert_free_period_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe && seen_one && !edge_since) |-> (gap == GAP_W'(OSR)))
    else $error("free-running period wrong");

endmodule

// File: rtl/usb_fs_rx_recover.sv
`timescale 1ns/1ps
module usb_fs_rx_recover #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dp_in,
  input  logic       dn_in,
  output logic       bit_valid,
  output logic [1:0] line_st
);
  import usb_rx_pkg::*;

  line_t line_now;
  logic  strobe;

  usb_rx_sync #(
    .STAGES (SYNC_STAGES),
    .W      (2),
    .RST_VAL(LINE_J)
  ) sync_i (
    .clk(clk),
    .rst(rst),
    .d  ({dp_in, dn_in}),
    .q  (line_now)
  );

  usb_rx_phase phase_i (
    .clk     (clk),
    .rst     (rst),
    .line_now(line_now),
    .strobe  (strobe)
  );

  // Registered hand-off: no decode glitch reaches the outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid <= 1'b0;
      line_st   <= LINE_J;
    end else begin
      bit_valid <= strobe;
      if (strobe) line_st <= line_now;
    end
  end

  // Checker: has the synchronized line left idle since reset?
  logic moved;
  always_ff @(posedge clk) begin
    if (rst)                    moved <= 1'b0;
    else if (line_now != LINE_J) moved <= 1'b1;
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid)
    else $error("bit_valid high on consecutive cycles");

  assert_hold_state_R9: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> $stable(line_st))
    else $error("line_st changed without bit_valid");

  assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> moved)
    else $error("pulse before first line change");

endmodule

// File: tb/usb_fs_rx_recover_tb.sv
`timescale 1ns/1ps
module usb_fs_rx_recover_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] CJ = 2'b10, CK = 2'b01, C0 = 2'b00, C1 = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dp_in = 1'b1;
  logic dn_in = 1'b0;
  wire        bit_valid;
  wire  [1:0] line_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_fs_rx_recover dut_i (
    .clk(clk), .rst(rst), .dp_in(dp_in), .dn_in(dn_in),
    .bit_valid(bit_valid), .line_st(line_st)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // Behavioural reference state
  logic [1:0] m_s1, m_s2, m_prev, m_line;
  int  m_ph;
  bit  m_armed, m_delay, m_valid;

  // Observation state
  logic [1:0] rx_q[$];
  int  last_v, last_chg, first_drive, first_valid;
  bit  prev_valid;
  logic [1:0] prev_line;
  logic [1:0] driven;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One posedge as seen by the reference, using the levels held across it.
  task automatic model_step();
    bit ch, fire;
    int nph;
    if (rst) begin
      m_s1 = CJ; m_s2 = CJ; m_prev = CJ; m_line = CJ;
      m_ph = 0; m_armed = 0; m_delay = 0; m_valid = 0;
    end else begin
      ch   = (m_s2 != m_prev);
      fire = m_armed && (m_ph == 2);
      m_valid = fire;
      if (fire) m_line = m_s2;
      if (!m_armed) begin
        if (ch) begin nph = 1; m_armed = 1; end
        else nph = (m_ph + 1) % 4;
      end else if (!ch) begin
        nph = (m_ph + 1) % 4;
      end else begin
        // error of the edge against the ideal position (phase 0)
        case (m_ph)
          0, 3: nph = 1;                          // on time / one early
          1:    nph = m_delay ? 2 : 1;            // one late: wait once
          default: nph = 0;                       // half cell: step one
        endcase
        if (m_ph == 1 && !m_delay) m_delay = 1;
        else if (fire) m_delay = 0;
      end
      if (m_armed && !ch && fire) m_delay = 0;
      m_ph   = nph;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = {dp_in, dn_in};
    end
  endtask

  task automatic tick(input logic [1:0] code, input bit r, input bit tail);
    @(negedge clk);
    cyc++;
    model_step();
    check(bit_valid === m_valid, "R6", "bit_valid vs model", int'(bit_valid), int'(m_valid));
    check(line_st === m_line, "R2", "line_st vs model", int'(line_st), int'(m_line));
    if (!rst) begin
      check(!(bit_valid && prev_valid), "R8", "consecutive pulse", 1, 0);
      check(bit_valid || line_st === prev_line, "R9", "line_st moved without pulse",
            int'(line_st), int'(prev_line));
      if (bit_valid) begin
        rx_q.push_back(line_st);
        if (first_valid < 0) first_valid = cyc;
        if (last_v >= 0) begin
          check(cyc - last_v >= 3 && cyc - last_v <= 5, "R5", "pulse gap", cyc - last_v, 4);
          if (tail && last_v > last_chg + 6)
            check(cyc - last_v == 4, "R4", "idle gap", cyc - last_v, 4);
        end
        last_v = cyc;
      end
    end
    prev_valid = bit_valid;
    prev_line  = line_st;
    if (code != driven) last_chg = cyc;
    if (code != CJ && first_drive < 0 && !r) first_drive = cyc;
    driven = code;
    {dp_in, dn_in} = code;
    rst = r;
  endtask

  task automatic do_reset();
    for (int i = 0; i < 4; i++) tick(CJ, 1'b1, 1'b0);
    tick(CJ, 1'b0, 1'b0);
    rx_q.delete();
    last_v = -1; first_drive = -1; first_valid = -1;
    for (int i = 0; i < 20; i++) begin
      tick(CJ, 1'b0, 1'b0);
      check(bit_valid === 1'b0, "R3", "pulse while idle after reset", int'(bit_valid), 0);
      check(line_st === CJ, "R3", "line_st after reset", int'(line_st), int'(CJ));
    end
  endtask

  // bitlen in thousandths of a clock; offs in clocks
  task automatic run_stream(input int bitlen, input int offs, input int nbits,
                            input int unsigned seed, input bit with_se1);
    logic [1:0] tx[$];
    logic [1:0] cur;
    int run, total, idx, ncmp;
    int unsigned st;
    longint t;
    do_reset();
    st = seed;
    for (int i = 0; i < 8; i++) tx.push_back(CJ);
    cur = CK; tx.push_back(cur); run = 1;
    for (int i = 0; i < nbits; i++) begin
      st = st * 32'd1664525 + 32'd1013904223;
      if (run >= 6 || st[16]) begin cur = (cur == CJ) ? CK : CJ; run = 1; end
      else run++;
      if (with_se1 && i == nbits / 2) begin
        tx.push_back(C1);
        cur = CJ; run = 1;   // bit after the SE1 cell
      end
      tx.push_back(cur);
    end
    tx.push_back(C0); tx.push_back(C0); tx.push_back(CJ);
    for (int i = 0; i < 8; i++) tx.push_back(CJ);
    total = offs + int'((longint'(tx.size()) * bitlen) / 1000) + 40;
    for (int c = 0; c < total; c++) begin
      if (c < offs) idx = -1;
      else begin
        t = longint'(c - offs) * 1000;
        idx = int'(t / bitlen);
      end
      tick((idx >= 0 && idx < tx.size()) ? tx[idx] : CJ, 1'b0, idx >= tx.size() + 2);
    end
    check(first_valid - first_drive == 5, "R1", "first pulse latency",
          first_valid - first_drive, 5);
    ncmp = tx.size() - 9;
    check(rx_q.size() >= ncmp, "R7", "recovered bit count", rx_q.size(), ncmp);
    for (int i = 0; i < ncmp && i < rx_q.size(); i++)
      check(rx_q[i] === tx[8 + i], "R7", $sformatf("bit %0d len %0d", i, bitlen),
            int'(rx_q[i]), int'(tx[8 + i]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    prev_valid = 1'b0; prev_line = CJ; driven = CJ;
    last_v = -1; last_chg = 0; first_drive = -1; first_valid = -1;
    run_stream(4000, 0, 120, 32'd1, 1'b0);   // nominal
    run_stream(4010, 1, 300, 32'd7, 1'b0);   // sender 0.25 % slow
    run_stream(3990, 2, 300, 32'd11, 1'b0);  // sender 0.25 % fast
    run_stream(4000, 3, 80, 32'd5, 1'b1);    // SE1 and SE0 cells
    run_stream(4010, 2, 200, 32'd23, 1'b1);
    run_stream(3990, 3, 200, 32'd29, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule